// File: doc/BRIEF.md
# Rename Map Table with Reorder-Buffer Tags

This block keeps, for every architectural register, a note of where the youngest value of that register will come from. The value is either already in the register file or still waiting in a reorder-buffer slot, and the slot is named by its tag. At issue, the front end reads the mappings of two source registers. It then points the destination register at the reorder-buffer slot it has just allocated. At retirement, the commit stage sends the destination register and the tag of the retiring slot. The mapping returns to the register file only if it still names that slot. A later rename of the same register has moved the mapping to a younger slot, and that mapping must stay in place.

A flush input, used for a branch misprediction or an exception at commit, returns every mapping to the register file at once. This block holds no data values. It holds only the pending bit and the tag for each register.

Top module: `rename_map_table`

## Requirements
- R1: After reset is released, every register reads as not pending with tag 0.
- R2: Each of the two lookup ports returns, in the same cycle and without a clock edge, the pending bit and tag of the register it selects. The tag reads as 0 whenever the pending bit is 0.
- R3: A rename write with `ren_en` high makes the selected register read pending with `ren_tag` from the next cycle on. This holds whatever the register's previous state was.
- R4: A lookup of a register that is being renamed in the same cycle returns the mapping from before that rename.
- R5: A commit with `cmt_en` high, on a register that is pending with a tag equal to `cmt_tag`, makes that register read not pending with tag 0 from the next cycle.
- R6: A commit on a register that is pending with a different tag, or that is not pending, leaves its mapping unchanged.
- R7: When a rename and a commit select the same register in the same cycle, the rename result is kept, even if the commit tag matched the old mapping.
- R8: A flush makes every register read not pending from the next cycle. It overrides any rename or commit presented in the same cycle.
- R9: A rename and a commit that select different registers in the same cycle both take effect, and registers selected by neither keep their mappings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Return all mappings to the register file |
| rd0_reg | input | 5 | Register selected by lookup port 0 |
| rd0_pend | output | 1 | Port 0: value pending in the reorder buffer |
| rd0_tag | output | 4 | Port 0: reorder-buffer tag (0 when not pending) |
| rd1_reg | input | 5 | Register selected by lookup port 1 |
| rd1_pend | output | 1 | Port 1: value pending in the reorder buffer |
| rd1_tag | output | 4 | Port 1: reorder-buffer tag (0 when not pending) |
| ren_en | input | 1 | Rename write enable |
| ren_reg | input | 5 | Destination register being renamed |
| ren_tag | input | 4 | Newly allocated reorder-buffer tag |
| cmt_en | input | 1 | Commit-clear enable |
| cmt_reg | input | 5 | Destination register of the retiring slot |
| cmt_tag | input | 4 | Tag of the retiring slot |

## Verification
The hardest case to reach is a commit that arrives for a register after a younger rename has already replaced its mapping. In the same family are a commit and a rename that hit one register in the same cycle. Purely random register and tag choices seldom line up this way. The stimulus therefore draws registers mostly from a small pool and usually takes the commit tag from the current mapping in the bench's model, so that matching and stale commits both occur often. Directed sequences force the exact stale-commit, same-cycle-collision and flush-over-rename orders.

// File: rtl/rmt_pkg.sv
// Package rmt_pkg
// Shared definitions for the rename map table: the next-state
// decision each entry makes on a clock edge, and the function that
// resolves the competing update sources for one entry.
// Assumes the caller has already decoded which entry each port selects.
package rmt_pkg;

    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_CLEAR = 2'd1,
        UPD_MAP   = 2'd2
    } upd_kind_e;

    // Priority: flush, then rename, then a commit whose tag still matches.
    function automatic upd_kind_e pick_update(
        input logic flush_i,
        input logic ren_hit_i,
        input logic cmt_hit_i,
        input logic tag_match_i,
        input logic pend_i
    );
        upd_kind_e kind;
        if (flush_i)
            kind = UPD_CLEAR;
        else if (ren_hit_i)
            kind = UPD_MAP;
        else if (cmt_hit_i && pend_i && tag_match_i)
            kind = UPD_CLEAR;
        else
            kind = UPD_HOLD;
        return kind;
    endfunction

endpackage

// File: rtl/rmt_decode.sv
// Module rmt_decode
// Turns an enable and a register index into a one-hot select vector
// with one bit per architectural register.
// Assumes the index is below NUM_AREGS. Larger indices select nothing.
module rmt_decode #(
    parameter int NUM_AREGS = 32,
    localparam int AREG_W   = $clog2(NUM_AREGS)
) (
    input  logic                 en,
    input  logic [AREG_W-1:0]    idx,
    output logic [NUM_AREGS-1:0] sel
);

    // One comparator per entry, gated by the enable.
    genvar gi;
    generate
        for (gi = 0; gi < NUM_AREGS; gi++) begin : g_dec
            assign sel[gi] = en && (idx == AREG_W'(gi));
        end
    endgenerate

endmodule

// File: rtl/rmt_entry.sv
// Module rmt_entry
// One architectural register's mapping: a pending bit and the
// reorder-buffer tag that will produce the value. The entry resolves
// flush, rename and commit-clear itself, using the package priority
// function. When an entry is cleared its tag goes to zero.
// Assumes the rename and commit selects are one-hot across entries.
module rmt_entry
    import rmt_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             ren_hit,
    input  logic [TAG_W-1:0] ren_tag,
    input  logic             cmt_hit,
    input  logic [TAG_W-1:0] cmt_tag,
    output logic             pend_q,
    output logic [TAG_W-1:0] tag_q
);

    upd_kind_e kind;

    // Decide this cycle's update for the entry.
    always_comb begin
        kind = pick_update(flush, ren_hit, cmt_hit, (tag_q == cmt_tag), pend_q);
    end

    // Hold or change the mapping on the clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            tag_q  <= '0;
        end else begin
            unique case (kind)
                UPD_MAP: begin
                    pend_q <= 1'b1;
                    tag_q  <= ren_tag;
                end
                UPD_CLEAR: begin
                    pend_q <= 1'b0;
                    tag_q  <= '0;
                end
                default: begin
                    pend_q <= pend_q;
                    tag_q  <= tag_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/rmt_lookup.sv
// Module rmt_lookup
// One source-lookup port. It selects a register's registered mapping
// with no clock edge in the path, so it always shows the state from
// before any update presented in the same cycle.
// Assumes the entries already hold tag zero when not pending.
module rmt_lookup #(
    parameter int NUM_AREGS = 32,
    parameter int TAG_W     = 4,
    localparam int AREG_W   = $clog2(NUM_AREGS)
) (
    input  logic [NUM_AREGS-1:0]            pend_vec,
    input  logic [NUM_AREGS-1:0][TAG_W-1:0] tag_vec,
    input  logic [AREG_W-1:0]               sel,
    output logic                            pend,
    output logic [TAG_W-1:0]                tag
);

    // Plain index mux; gate the tag so it never shows a stale value.
    always_comb begin
        pend = pend_vec[sel];
        tag  = pend ? tag_vec[sel] : '0;
    end

endmodule

// File: rtl/rename_map_table.sv
// Module rename_map_table (top)
// Rename table with one entry per architectural register. It has two
// combinational source lookups, one rename write, one tag-checked
// commit clear and a flush that clears everything.
// Assumes one rename and one commit per cycle at most, and a
// synchronous active-low reset.
module rename_map_table #(
    parameter int NUM_AREGS = 32,
    parameter int TAG_W     = 4,
    localparam int AREG_W   = $clog2(NUM_AREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [AREG_W-1:0] rd0_reg,
    output logic              rd0_pend,
    output logic [TAG_W-1:0]  rd0_tag,
    input  logic [AREG_W-1:0] rd1_reg,
    output logic              rd1_pend,
    output logic [TAG_W-1:0]  rd1_tag,
    input  logic              ren_en,
    input  logic [AREG_W-1:0] ren_reg,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              cmt_en,
    input  logic [AREG_W-1:0] cmt_reg,
    input  logic [TAG_W-1:0]  cmt_tag
);

    logic [NUM_AREGS-1:0]            ren_sel;
    logic [NUM_AREGS-1:0]            cmt_sel;
    logic [NUM_AREGS-1:0]            pend_vec;
    logic [NUM_AREGS-1:0][TAG_W-1:0] tag_vec;

    // Decode the rename destination.
    rmt_decode #(.NUM_AREGS(NUM_AREGS)) u_ren_dec (
        .en (ren_en),
        .idx(ren_reg),
        .sel(ren_sel)
    );

    // Decode the commit destination.
    rmt_decode #(.NUM_AREGS(NUM_AREGS)) u_cmt_dec (
        .en (cmt_en),
        .idx(cmt_reg),
        .sel(cmt_sel)
    );

    // One storage entry per architectural register.
    genvar gi;
    generate
        for (gi = 0; gi < NUM_AREGS; gi++) begin : g_ent
            rmt_entry #(.TAG_W(TAG_W)) u_ent (
                .clk    (clk),
                .rst_n  (rst_n),
                .flush  (flush),
                .ren_hit(ren_sel[gi]),
                .ren_tag(ren_tag),
                .cmt_hit(cmt_sel[gi]),
                .cmt_tag(cmt_tag),
                .pend_q (pend_vec[gi]),
                .tag_q  (tag_vec[gi])
            );
        end
    endgenerate

    // Source lookup port 0.
    rmt_lookup #(.NUM_AREGS(NUM_AREGS), .TAG_W(TAG_W)) u_look0 (
        .pend_vec(pend_vec),
        .tag_vec (tag_vec),
        .sel     (rd0_reg),
        .pend    (rd0_pend),
        .tag     (rd0_tag)
    );

    // Source lookup port 1.
    rmt_lookup #(.NUM_AREGS(NUM_AREGS), .TAG_W(TAG_W)) u_look1 (
        .pend_vec(pend_vec),
        .tag_vec (tag_vec),
        .sel     (rd1_reg),
        .pend    (rd1_pend),
        .tag     (rd1_tag)
    );

endmodule

// File: rtl/rename_map_table_checker.sv
// Module rename_map_table_checker
// Port-level temporal checks on the rename map table. Lookup port 0
// serves as the observer: each property relates an update seen on
// one cycle to what port 0 reads back on the next cycle.
// Assumes it is bound to rename_map_table.
module rename_map_table_checker #(
    parameter int NUM_AREGS = 32,
    parameter int TAG_W     = 4,
    localparam int AREG_W   = $clog2(NUM_AREGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic [AREG_W-1:0] rd0_reg,
    input logic              rd0_pend,
    input logic [TAG_W-1:0]  rd0_tag,
    input logic              ren_en,
    input logic [AREG_W-1:0] ren_reg,
    input logic [TAG_W-1:0]  ren_tag,
    input logic              cmt_en,
    input logic [AREG_W-1:0] cmt_reg,
    input logic [TAG_W-1:0]  cmt_tag
);

    // R1: the first cycle out of reset shows no pending mapping.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!rd0_pend && rd0_tag == '0));

    // R3: a rename shows up on the next cycle.
    a_r3_rename_maps: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && ren_en && !flush) && rd0_reg == $past(ren_reg))
        |-> (rd0_pend && rd0_tag == $past(ren_tag)));

    // R5: a commit with a matching tag clears the entry.
    a_r5_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && cmt_en && !flush && !(ren_en && ren_reg == cmt_reg)
               && rd0_reg == cmt_reg && rd0_pend && rd0_tag == cmt_tag)
         && rd0_reg == $past(cmt_reg))
        |-> !rd0_pend);

    // R6: a commit with a different tag leaves the entry alone.
    a_r6_stale_commit_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && cmt_en && !flush && !(ren_en && ren_reg == cmt_reg)
               && rd0_reg == cmt_reg && rd0_pend && rd0_tag != cmt_tag)
         && rd0_reg == $past(cmt_reg))
        |-> (rd0_pend && rd0_tag == $past(rd0_tag)));

    // R7: a rename beats a commit on the same register.
    a_r7_rename_beats_commit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && ren_en && cmt_en && ren_reg == cmt_reg && !flush)
         && rd0_reg == $past(ren_reg))
        |-> rd0_pend);

    // R8: a flush clears every register.
    a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && flush) |-> !rd0_pend);

    // R9: with no update at all, a steady lookup stays steady.
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && !ren_en && !cmt_en && !flush) && $stable(rd0_reg))
        |-> ($stable(rd0_pend) && $stable(rd0_tag)));

endmodule

bind rename_map_table rename_map_table_checker #(
    .NUM_AREGS(NUM_AREGS),
    .TAG_W    (TAG_W)
) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .rd0_reg (rd0_reg),
    .rd0_pend(rd0_pend),
    .rd0_tag (rd0_tag),
    .ren_en  (ren_en),
    .ren_reg (ren_reg),
    .ren_tag (ren_tag),
    .cmt_en  (cmt_en),
    .cmt_reg (cmt_reg),
    .cmt_tag (cmt_tag)
);

// File: tb/rename_map_table_bench.sv
// Bench for rename_map_table: directed corner sequences, then seeded
// random traffic, all checked against a reference model in the bench.
module rename_map_table_bench;

    localparam int NA = 32;
    localparam int TW = 4;
    localparam int AW = $clog2(NA);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic [AW-1:0] rd0_reg = '0, rd1_reg = '0;
    logic          rd0_pend, rd1_pend;
    logic [TW-1:0] rd0_tag, rd1_tag;
    logic          ren_en = 1'b0, cmt_en = 1'b0;
    logic [AW-1:0] ren_reg = '0, cmt_reg = '0;
    logic [TW-1:0] ren_tag = '0, cmt_tag = '0;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    bit          m_pend [NA];
    logic [TW-1:0] m_tag [NA];

    always #5 clk = ~clk;

    rename_map_table #(.NUM_AREGS(NA), .TAG_W(TW)) u_rename_map_table (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .rd0_reg(rd0_reg), .rd0_pend(rd0_pend), .rd0_tag(rd0_tag),
        .rd1_reg(rd1_reg), .rd1_pend(rd1_pend), .rd1_tag(rd1_tag),
        .ren_en(ren_en), .ren_reg(ren_reg), .ren_tag(ren_tag),
        .cmt_en(cmt_en), .cmt_reg(cmt_reg), .cmt_tag(cmt_tag)
    );

    function automatic logic [TW-1:0] exp_tag(input int r);
        return m_pend[r] ? m_tag[r] : '0;
    endfunction

    // Reference update following R3, R5 to R9.
    function automatic void model_step();
        if (flush) begin
            for (int i = 0; i < NA; i++) begin m_pend[i] = 0; m_tag[i] = '0; end
        end else begin
            if (cmt_en && m_pend[cmt_reg] && m_tag[cmt_reg] == cmt_tag
                && !(ren_en && ren_reg == cmt_reg)) begin
                m_pend[cmt_reg] = 0; m_tag[cmt_reg] = '0;
            end
            if (ren_en) begin m_pend[ren_reg] = 1; m_tag[ren_reg] = ren_tag; end
        end
    endfunction

    task automatic check(input string req, input bit ap, input logic [TW-1:0] at,
                         input bit ep, input logic [TW-1:0] et);
        tests++;
        if (ap !== ep || at !== et) begin
            fails++;
            $display("FAIL %s: got pend=%0d tag=%0d, expected pend=%0d tag=%0d",
                     req, ap, at, ep, et);
        end
    endtask

    // Apply inputs at the falling edge, let them settle, check both ports against the model.
    task automatic cycle(input string req, input bit fl,
                         input bit re, input int rr, input int rt,
                         input bit ce, input int cr, input int ct,
                         input int r0, input int r1);
        @(negedge clk);
        flush = fl; ren_en = re; ren_reg = AW'(rr); ren_tag = TW'(rt);
        cmt_en = ce; cmt_reg = AW'(cr); cmt_tag = TW'(ct);
        rd0_reg = AW'(r0); rd1_reg = AW'(r1);
        #1;
        check(req, rd0_pend, rd0_tag, m_pend[r0], exp_tag(r0));
        check(req, rd1_pend, rd1_tag, m_pend[r1], exp_tag(r1));
        model_step();
    endtask

    task automatic idle_look(input string req, input int r0, input int r1);
        cycle(req, 0, 0, 0, 0, 0, 0, 0, r0, r1);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NA; i++) begin m_pend[i] = 0; m_tag[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: everything clear after reset.
        idle_look("R1", 0, 31);
        idle_look("R1", 5, 17);

        // R4: lookup during rename sees the old mapping; R3 next cycle.
        cycle("R4", 0, 1, 5, 3, 0, 0, 0, 5, 5);
        idle_look("R3", 5, 6);
        // R3: rename over a pending entry with a newer tag.
        cycle("R3", 0, 1, 5, 7, 0, 0, 0, 5, 0);
        // R6: stale commit (tag 3) must not clear the newer tag 7.
        cycle("R6", 0, 0, 0, 0, 1, 5, 3, 5, 5);
        idle_look("R6", 5, 5);
        // R6: commit on a register that is not pending.
        cycle("R6", 0, 0, 0, 0, 1, 8, 0, 8, 5);
        idle_look("R6", 8, 5);
        // R5: matching commit clears.
        cycle("R5", 0, 0, 0, 0, 1, 5, 7, 5, 5);
        idle_look("R5", 5, 5);
        // R7: same-register rename and matching commit.
        cycle("R3", 0, 1, 9, 2, 0, 0, 0, 9, 9);
        cycle("R7", 0, 1, 9, 11, 1, 9, 2, 9, 9);
        idle_look("R7", 9, 9);
        // R9: rename and commit on different registers together.
        cycle("R9", 0, 1, 12, 4, 1, 9, 11, 12, 9);
        idle_look("R9", 12, 9);
        // R8: flush overrides a rename in the same cycle.
        cycle("R8", 0, 1, 20, 6, 0, 0, 0, 20, 12);
        cycle("R8", 1, 1, 21, 5, 1, 20, 6, 20, 21);
        idle_look("R8", 20, 21);
        idle_look("R8", 12, 9);

        // Random traffic from a small register pool, with commit tags mostly taken from the model.
        for (int n = 0; n < 3000; n++) begin
            int rr, cr, ct, r0, r1;
            bit re, ce, fl;
            string req;
            rr = ($urandom % 2) ? int'($urandom % 4) : int'($urandom % NA);
            cr = ($urandom % 3 == 0) ? rr : int'($urandom % 4);
            r0 = ($urandom % 2) ? rr : int'($urandom % 4);
            r1 = int'($urandom % NA);
            re = ($urandom % 100) < 60;
            ce = ($urandom % 100) < 60;
            fl = ($urandom % 100) < 3;
            ct = ($urandom % 10 < 7) ? int'(m_tag[cr]) : int'($urandom % 16);
            req = (re && r0 == rr) ? "R4" : "R2";
            cycle(req, fl, re, rr, int'($urandom % 16), ce, cr, ct, r0, r1);
        end
        idle_look("R2", 0, 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule